// File: doc/BRIEF.md
# Downstream Management Broadcast Decoder

This block sits in a device on the downstream side of a packet link. It watches the incoming request stream for broadcast system-management packets. These are packets whose command field holds the posted-broadcast code and whose upper address bits carry the management tag. For each accepted packet it decodes the 8-bit management message byte. The upper nibble picks the operation and the lower nibble carries signal states or an action code.

Level-type messages, or "virtual wires", update persistent sideband outputs. These are ignore-numeric-error, A20 mask, floating-point error, stop-clock and SMI acknowledge. The block also keeps a 3-bit action code taken from the stop-clock and stop-grant messages. Special-cycle messages raise a strobe for a single clock.

Every accepted management packet is also copied, unchanged, to a forwarding output one clock later, so that the message keeps travelling along the chain whatever it decodes to. Reserved bits and reserved operation codes do not move any sideband output.

Top module: `mgmt_bcast_decoder`

## Requirements
- R1: After reset (`rst_n` low) all five level outputs are 0, `action_code` is 0, every strobe output is 0 and `fwd_valid` is 0.
- R2: A packet is accepted only when `in_valid` is 1, `in_cmd` equals 6'b111010 and `in_addr` equals 20'hFDF91. Any other input leaves every level, the action code and every strobe unchanged or low, and is not forwarded.
- R3: An accepted packet drives `fwd_valid` high for exactly the next clock, with `fwd_cmd`, `fwd_addr` and `fwd_msg` equal to the accepted inputs. This includes packets with reserved operation codes.
- R4: Operation 4'b0001 in `in_msg[7:4]` sets `lvl_numerr_ignore` from `in_msg[0]` and `lvl_a20_mask` from `in_msg[1]`, one clock after acceptance. `in_msg[3:2]` has no effect.
- R5: Operation 4'b0010 sets `lvl_fp_error` from `in_msg[0]`. `in_msg[3:1]` has no effect.
- R6: Operation 4'b0011 sets `lvl_stop_clk` from `in_msg[0]` and loads `action_code` from `in_msg[3:1]`.
- R7: Operation 4'b0110 pulses `pulse_stop_grant` and loads `action_code` from `in_msg[3:1]`. `in_msg[0]` has no effect and `lvl_stop_clk` is unchanged.
- R8: Operation 4'b1010 sets `lvl_smi_ack` from `in_msg[0]`.
- R9: Operations 4'b0100 (halt), 4'b0101 (shutdown), 4'b0111 (frequency/voltage change), 4'b1000 (write-back invalidate) and 4'b1001 (invalidate) each raise their own strobe for exactly one clock, whatever the low nibble holds. At most one strobe is high in any cycle.
- R10: Operations 4'b0000, 4'b1011 and 4'b11xx change no level, no action code and no strobe.
- R11: Each level output and the action code hold their value until an accepted packet of an operation that writes them arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming request present this cycle |
| in_cmd | input | 6 | Incoming request command field |
| in_addr | input | 20 | Incoming request address bits 39:20 |
| in_msg | input | 8 | Management message byte |
| fwd_valid | output | 1 | Forwarded management packet present |
| fwd_cmd | output | 6 | Forwarded command field |
| fwd_addr | output | 20 | Forwarded address bits 39:20 |
| fwd_msg | output | 8 | Forwarded message byte |
| lvl_numerr_ignore | output | 1 | Ignore-numeric-error level |
| lvl_a20_mask | output | 1 | A20 mask level |
| lvl_fp_error | output | 1 | Floating-point error level |
| lvl_stop_clk | output | 1 | Stop-clock level |
| lvl_smi_ack | output | 1 | SMI acknowledge level |
| action_code | output | 3 | Most recent action code |
| pulse_halt | output | 1 | Halt special-cycle strobe |
| pulse_shutdown | output | 1 | Shutdown special-cycle strobe |
| pulse_vf_change | output | 1 | Frequency/voltage change strobe |
| pulse_wb_inval | output | 1 | Write-back invalidate strobe |
| pulse_inval | output | 1 | Invalidate strobe |
| pulse_stop_grant | output | 1 | Stop-grant special-cycle strobe |

## Verification
Every result is registered once, so each level, the action code, each strobe and the forwarded copy are due exactly one clock after the cycle in which a packet is presented. The bench drives one input set per cycle at the falling edge and queues the outputs it expects for the next cycle. It then compares them just after the following rising edge, so every idle or rejected cycle is compared as well. Back-to-back strobe packets show that a strobe lasts exactly one clock.

// File: rtl/mgmt_dn_pkg.sv
// Package: shared constants, operation codes, strobe slot indices and the
// decoded-update structure used by the downstream management decoder.
package mgmt_dn_pkg;

    localparam int unsigned CMD_W  = 6;
    localparam int unsigned ADDR_W = 20;
    localparam int unsigned MSG_W  = 8;
    localparam int unsigned ACT_W  = 3;

    localparam logic [CMD_W-1:0]  MGMT_BCAST_CMD = 6'b111010;
    localparam logic [ADDR_W-1:0] MGMT_ADDR_TAG  = 20'hFDF91;

    // Operation codes carried in message bits 7:4
    typedef enum logic [3:0] {
        OP_RSVD0    = 4'h0,
        OP_LEG_IN   = 4'h1,
        OP_LEG_OUT  = 4'h2,
        OP_STOPCLK  = 4'h3,
        OP_HALT     = 4'h4,
        OP_SHUTDOWN = 4'h5,
        OP_STOPGNT  = 4'h6,
        OP_VFCHG    = 4'h7,
        OP_WBINV    = 4'h8,
        OP_INV      = 4'h9,
        OP_SMIACK   = 4'hA,
        OP_PLAT     = 4'hB
    } mgmt_op_e;

    // Strobe slot indices
    localparam int unsigned STB_HALT  = 0;
    localparam int unsigned STB_SHUT  = 1;
    localparam int unsigned STB_VFCHG = 2;
    localparam int unsigned STB_WBINV = 3;
    localparam int unsigned STB_INV   = 4;
    localparam int unsigned STB_GRANT = 5;
    localparam int unsigned NUM_STB   = 6;

    // One decoded packet: which registers to write and which strobe to fire
    typedef struct packed {
        logic               wr_legacy_in;
        logic               wr_fp_err;
        logic               wr_stop_clk;
        logic               wr_smi_ack;
        logic               wr_action;
        logic [NUM_STB-1:0] pulse;
    } mgmt_dec_t;

endpackage

// File: rtl/mgmt_pkt_filter.sv
// Module: mgmt_pkt_filter
// Recognises broadcast management packets by command code and address tag,
// and registers an unchanged copy of each accepted packet for forwarding.
// Assumes one request per cycle qualified by in_valid; forward fields hold
// their last value while fwd_valid is low.
module mgmt_pkt_filter #(
    parameter int unsigned       CMD_W     = 6,
    parameter int unsigned       ADDR_W    = 20,
    parameter int unsigned       MSG_W     = 8,
    parameter logic [CMD_W-1:0]  MATCH_CMD = '0,
    parameter logic [ADDR_W-1:0] MATCH_TAG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MSG_W-1:0]  in_msg,
    output logic              hit,
    output logic              fwd_valid,
    output logic [CMD_W-1:0]  fwd_cmd,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [MSG_W-1:0]  fwd_msg
);

    // Acceptance test: valid request with broadcast code and management tag
    always_comb begin
        hit = in_valid && (in_cmd == MATCH_CMD) && (in_addr == MATCH_TAG);
    end

    // Forward valid: one cycle per accepted packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
        end else begin
            fwd_valid <= hit;
        end
    end

    // Forward payload: capture the accepted packet unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_cmd  <= '0;
            fwd_addr <= '0;
            fwd_msg  <= '0;
        end else if (hit) begin
            fwd_cmd  <= in_cmd;
            fwd_addr <= in_addr;
            fwd_msg  <= in_msg;
        end
    end

endmodule

// File: rtl/mgmt_op_decode.sv
// Module: mgmt_op_decode
// Purely combinational decode of the message byte of an accepted packet
// into register-write enables and a one-hot strobe request.
// Assumes hit already qualifies the packet; reserved codes produce nothing.
module mgmt_op_decode
    import mgmt_dn_pkg::*;
(
    input  logic             hit,
    input  logic [MSG_W-1:0] msg,
    output mgmt_dec_t        dec
);

    mgmt_op_e op;

    // Operation select from the upper nibble
    always_comb begin
        op = mgmt_op_e'(msg[7:4]);
    end

    // Map operation to write enables and strobe slot
    always_comb begin
        dec = '0;
        if (hit) begin
            case (op)
                OP_LEG_IN:   dec.wr_legacy_in     = 1'b1;
                OP_LEG_OUT:  dec.wr_fp_err        = 1'b1;
                OP_STOPCLK: begin
                    dec.wr_stop_clk = 1'b1;
                    dec.wr_action   = 1'b1;
                end
                OP_STOPGNT: begin
                    dec.wr_action        = 1'b1;
                    dec.pulse[STB_GRANT] = 1'b1;
                end
                OP_HALT:     dec.pulse[STB_HALT]  = 1'b1;
                OP_SHUTDOWN: dec.pulse[STB_SHUT]  = 1'b1;
                OP_VFCHG:    dec.pulse[STB_VFCHG] = 1'b1;
                OP_WBINV:    dec.pulse[STB_WBINV] = 1'b1;
                OP_INV:      dec.pulse[STB_INV]   = 1'b1;
                OP_SMIACK:   dec.wr_smi_ack       = 1'b1;
                default:     dec = '0;
            endcase
        end
    end

endmodule

// File: rtl/mgmt_wire_regs.sv
// Module: mgmt_wire_regs
// Persistent level registers for each virtual wire plus the action code.
// Assumes the decode enables are mutually exclusive per cycle.
module mgmt_wire_regs
    import mgmt_dn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mgmt_dec_t        dec,
    input  logic [3:0]       arg,
    output logic             numerr_ignore,
    output logic             a20_mask,
    output logic             fp_error,
    output logic             stop_clk,
    output logic             smi_ack,
    output logic [ACT_W-1:0] action
);

    // Legacy processor inputs: bit 0 and bit 1 of the argument
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            numerr_ignore <= 1'b0;
            a20_mask      <= 1'b0;
        end else if (dec.wr_legacy_in) begin
            numerr_ignore <= arg[0];
            a20_mask      <= arg[1];
        end
    end

    // Processor error output level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_error <= 1'b0;
        end else if (dec.wr_fp_err) begin
            fp_error <= arg[0];
        end
    end

    // Stop-clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_clk <= 1'b0;
        end else if (dec.wr_stop_clk) begin
            stop_clk <= arg[0];
        end
    end

    // SMI acknowledge level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_ack <= 1'b0;
        end else if (dec.wr_smi_ack) begin
            smi_ack <= arg[0];
        end
    end

    // Action code from argument bits 3:1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            action <= '0;
        end else if (dec.wr_action) begin
            action <= arg[ACT_W:1];
        end
    end

endmodule

// File: rtl/mgmt_strobe_gen.sv
// Module: mgmt_strobe_gen
// Registers the one-hot strobe request so each special cycle yields a
// single-clock pulse. Assumes one request per accepted packet.
module mgmt_strobe_gen #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] pulse
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Slot register: high for the clock after its request only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse[g] <= 1'b0;
            end else begin
                pulse[g] <= req[g];
            end
        end
    end

endmodule

// File: rtl/mgmt_bcast_decoder.sv
// Module: mgmt_bcast_decoder (top)
// Accepts broadcast management packets, forwards each one unchanged, keeps
// the virtual-wire levels and action code, and emits special-cycle strobes.
// All results appear one clock after the packet. Synchronous active-low reset.
module mgmt_bcast_decoder
    import mgmt_dn_pkg::*;
#(
    parameter logic [CMD_W-1:0]  MATCH_CMD = MGMT_BCAST_CMD,
    parameter logic [ADDR_W-1:0] MATCH_TAG = MGMT_ADDR_TAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [MSG_W-1:0]  in_msg,
    output logic              fwd_valid,
    output logic [CMD_W-1:0]  fwd_cmd,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [MSG_W-1:0]  fwd_msg,
    output logic              lvl_numerr_ignore,
    output logic              lvl_a20_mask,
    output logic              lvl_fp_error,
    output logic              lvl_stop_clk,
    output logic              lvl_smi_ack,
    output logic [ACT_W-1:0]  action_code,
    output logic              pulse_halt,
    output logic              pulse_shutdown,
    output logic              pulse_vf_change,
    output logic              pulse_wb_inval,
    output logic              pulse_inval,
    output logic              pulse_stop_grant
);

    logic               hit;
    mgmt_dec_t          dec;
    logic [NUM_STB-1:0] stb;

    mgmt_pkt_filter #(
        .CMD_W     (CMD_W),
        .ADDR_W    (ADDR_W),
        .MSG_W     (MSG_W),
        .MATCH_CMD (MATCH_CMD),
        .MATCH_TAG (MATCH_TAG)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_cmd    (in_cmd),
        .in_addr   (in_addr),
        .in_msg    (in_msg),
        .hit       (hit),
        .fwd_valid (fwd_valid),
        .fwd_cmd   (fwd_cmd),
        .fwd_addr  (fwd_addr),
        .fwd_msg   (fwd_msg)
    );

    mgmt_op_decode u_decode (
        .hit (hit),
        .msg (in_msg),
        .dec (dec)
    );

    mgmt_wire_regs u_wires (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec           (dec),
        .arg           (in_msg[3:0]),
        .numerr_ignore (lvl_numerr_ignore),
        .a20_mask      (lvl_a20_mask),
        .fp_error      (lvl_fp_error),
        .stop_clk      (lvl_stop_clk),
        .smi_ack       (lvl_smi_ack),
        .action        (action_code)
    );

    mgmt_strobe_gen #(
        .N (NUM_STB)
    ) u_strobes (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (dec.pulse),
        .pulse (stb)
    );

    // Strobe slots to named ports
    always_comb begin
        pulse_halt       = stb[STB_HALT];
        pulse_shutdown   = stb[STB_SHUT];
        pulse_vf_change  = stb[STB_VFCHG];
        pulse_wb_inval   = stb[STB_WBINV];
        pulse_inval      = stb[STB_INV];
        pulse_stop_grant = stb[STB_GRANT];
    end

endmodule

// File: rtl/mgmt_dn_checker.sv
// Module: mgmt_dn_checker
// Port-level properties of the decoder, attached to the top by bind.
module mgmt_dn_checker
    import mgmt_dn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CMD_W-1:0]  in_cmd,
    input logic [ADDR_W-1:0] in_addr,
    input logic [MSG_W-1:0]  in_msg,
    input logic              fwd_valid,
    input logic [MSG_W-1:0]  fwd_msg,
    input logic              lvl_numerr_ignore,
    input logic              lvl_a20_mask,
    input logic              lvl_fp_error,
    input logic              lvl_stop_clk,
    input logic              lvl_smi_ack,
    input logic [ACT_W-1:0]  action_code,
    input logic [NUM_STB-1:0] pulses
);

    logic       acc;
    logic [3:0] op;
    logic [4:0] lvls;
    logic       rsvd;

    always_comb begin
        acc  = in_valid && in_cmd == MGMT_BCAST_CMD && in_addr == MGMT_ADDR_TAG;
        op   = in_msg[7:4];
        lvls = {lvl_numerr_ignore, lvl_a20_mask, lvl_fp_error, lvl_stop_clk, lvl_smi_ack};
        rsvd = (op == 4'h0) || (op == 4'hB) || (op[3:2] == 2'b11);
    end

    a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (pulses == '0) && $stable(lvls) && $stable(action_code) && !fwd_valid);

    a_r3_forward_copy: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> fwd_valid && (fwd_msg == $past(in_msg)));

    a_r4_legacy_in: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h1) |=> (lvl_numerr_ignore == $past(in_msg[0])) && (lvl_a20_mask == $past(in_msg[1])));

    a_r5_fp_error: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h2) |=> lvl_fp_error == $past(in_msg[0]));

    a_r6_stop_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h3) |=> (lvl_stop_clk == $past(in_msg[0])) && (action_code == $past(in_msg[3:1])));

    a_r7_stop_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'h6) |=> pulses[STB_GRANT] && $stable(lvl_stop_clk) && (action_code == $past(in_msg[3:1])));

    a_r8_smi_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == 4'hA) |=> lvl_smi_ack == $past(in_msg[0]));

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    a_r9_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != '0) |=> (pulses == '0) || $past(acc));

    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rsvd) |=> (pulses == '0) && $stable(lvls) && $stable(action_code));

    a_r11_hold_smi: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && op == 4'hA) |=> $stable(lvl_smi_ack));

endmodule

bind mgmt_bcast_decoder mgmt_dn_checker u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .in_cmd            (in_cmd),
    .in_addr           (in_addr),
    .in_msg            (in_msg),
    .fwd_valid         (fwd_valid),
    .fwd_msg           (fwd_msg),
    .lvl_numerr_ignore (lvl_numerr_ignore),
    .lvl_a20_mask      (lvl_a20_mask),
    .lvl_fp_error      (lvl_fp_error),
    .lvl_stop_clk      (lvl_stop_clk),
    .lvl_smi_ack       (lvl_smi_ack),
    .action_code       (action_code),
    .pulses            ({pulse_stop_grant, pulse_inval, pulse_wb_inval,
                         pulse_vf_change, pulse_shutdown, pulse_halt})
);

// File: tb/tb_mgmt_bcast_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the outputs expected one clock after
// each input cycle; the monitor compares them just after the next rising edge.
module tb_mgmt_bcast_decoder;

    localparam logic [5:0]  BC  = 6'b111010;
    localparam logic [19:0] TAG = 20'hFDF91;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_cmd = '0;
    logic [19:0] in_addr = '0;
    logic [7:0]  in_msg = '0;
    logic        fwd_valid;
    logic [5:0]  fwd_cmd;
    logic [19:0] fwd_addr;
    logic [7:0]  fwd_msg;
    logic        lvl_numerr_ignore, lvl_a20_mask, lvl_fp_error, lvl_stop_clk, lvl_smi_ack;
    logic [2:0]  action_code;
    logic        pulse_halt, pulse_shutdown, pulse_vf_change, pulse_wb_inval, pulse_inval, pulse_stop_grant;

    always #2.5 clk = ~clk;

    mgmt_bcast_decoder dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_cmd (in_cmd), .in_addr (in_addr), .in_msg (in_msg),
        .fwd_valid (fwd_valid), .fwd_cmd (fwd_cmd), .fwd_addr (fwd_addr), .fwd_msg (fwd_msg),
        .lvl_numerr_ignore (lvl_numerr_ignore), .lvl_a20_mask (lvl_a20_mask),
        .lvl_fp_error (lvl_fp_error), .lvl_stop_clk (lvl_stop_clk), .lvl_smi_ack (lvl_smi_ack),
        .action_code (action_code),
        .pulse_halt (pulse_halt), .pulse_shutdown (pulse_shutdown),
        .pulse_vf_change (pulse_vf_change), .pulse_wb_inval (pulse_wb_inval),
        .pulse_inval (pulse_inval), .pulse_stop_grant (pulse_stop_grant)
    );

    // Expected item: fwd valid/cmd/addr/msg, levels {ign,a20,ferr,stop,smi},
    // action, strobes {halt,shut,vf,wbinv,inv,grant}
    typedef struct packed {
        logic        fv;
        logic [5:0]  fc;
        logic [19:0] fa;
        logic [7:0]  fm;
        logic [4:0]  lv;
        logic [2:0]  act;
        logic [5:0]  stb;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Bench model state
    logic [4:0] m_lv = '0;
    logic [2:0] m_act = '0;

    task automatic check_item(input exp_t e, input string tag);
        exp_t a;
        a.fv = fwd_valid; a.fc = fwd_cmd; a.fa = fwd_addr; a.fm = fwd_msg;
        a.lv = {lvl_numerr_ignore, lvl_a20_mask, lvl_fp_error, lvl_stop_clk, lvl_smi_ack};
        a.act = action_code;
        a.stb = {pulse_halt, pulse_shutdown, pulse_vf_change, pulse_wb_inval, pulse_inval, pulse_stop_grant};
        n_chk++;
        if (a.fv != e.fv || a.lv != e.lv || a.act != e.act || a.stb != e.stb ||
            (e.fv && (a.fc != e.fc || a.fa != e.fa || a.fm != e.fm))) begin
            n_bad++;
            $display("FAIL %s: fv=%0b lv=%05b act=%0d stb=%06b fwd=%h/%h/%h expected fv=%0b lv=%05b act=%0d stb=%06b fwd=%h/%h/%h",
                     tag, a.fv, a.lv, a.act, a.stb, a.fc, a.fa, a.fm,
                     e.fv, e.lv, e.act, e.stb, e.fc, e.fa, e.fm);
        end
    endtask

    // Driver: present one cycle of input and queue the next-cycle expectation
    task automatic drive(input logic v, input logic [5:0] c, input logic [19:0] ad,
                         input logic [7:0] m, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        in_valid = v; in_cmd = c; in_addr = ad; in_msg = m;
        acc = v && c == BC && ad == TAG;
        e = '0;
        e.fv = acc; e.fc = c; e.fa = ad; e.fm = m;
        if (acc) begin
            case (m[7:4])
                4'h1: begin m_lv[4] = m[0]; m_lv[3] = m[1]; end
                4'h2: m_lv[2] = m[0];
                4'h3: begin m_lv[1] = m[0]; m_act = m[3:1]; end
                4'h6: begin m_act = m[3:1]; e.stb[0] = 1'b1; end
                4'hA: m_lv[0] = m[0];
                4'h4: e.stb[5] = 1'b1;
                4'h5: e.stb[4] = 1'b1;
                4'h7: e.stb[3] = 1'b1;
                4'h8: e.stb[2] = 1'b1;
                4'h9: e.stb[1] = 1'b1;
                default: ;
            endcase
        end
        e.lv = m_lv; e.act = m_act;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [7:0] m, input string tag);
        drive(1'b1, BC, TAG, m, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, '0, '0, '0, tag);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check_item(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        // R1: reset state, sampled while reset is still applied
        #1;
        r = '0;
        check_item(r, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: rejected inputs
        drive(1'b1, 6'b101000, TAG, 8'h13, "R2 wrong cmd");
        drive(1'b1, BC, 20'hFDF90, 8'h13, "R2 wrong addr");
        drive(1'b0, BC, TAG, 8'h4F, "R2 valid low");
        // R4 legacy inputs, bits 3:2 ignored
        send(8'h13, "R4 set both, R3 fwd");
        send(8'h1C, "R4 clear, bits 3:2 ignored");
        send(8'h1D, "R4 ign only");
        // R5
        send(8'h2F, "R5 ferr set");
        send(8'h2E, "R5 ferr clear");
        send(8'h21, "R5 ferr set");
        // R6
        send(8'h3B, "R6 stop set act5");
        send(8'h36, "R6 stop clear act3");
        // R7: stop grant, bit 0 ignored, stop level unchanged
        send(8'h69, "R7 grant act4");
        idle("R11 hold");
        send(8'h3F, "R6 stop set act7");
        send(8'h62, "R7 grant act1 stop kept");
        // R8
        send(8'hA1, "R8 smi set");
        send(8'hAE, "R8 smi clear");
        send(8'hA7, "R8 smi set");
        // R9 back to back strobes
        send(8'h4F, "R9 halt");
        send(8'h50, "R9 shutdown");
        send(8'h7A, "R9 vf change");
        send(8'h83, "R9 wbinv");
        send(8'h9C, "R9 inv");
        idle("R9 strobe drops");
        // R10 reserved codes, still forwarded (R3)
        send(8'h0F, "R10 code 0");
        send(8'hB3, "R10 code B");
        send(8'hC5, "R10 code C");
        send(8'hFF, "R10 code F");
        drive(1'b1, 6'b111011, TAG, 8'hA0, "R2 near cmd");
        idle("R11 hold");
        idle("R11 hold");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule